// File: doc/BRIEF.md
# Shared Issue-Queue Entry Allocator for Multithreaded Cores

This block keeps the books for an instruction queue whose entries are shared by several hardware threads. It holds one occupancy counter per thread and one global free counter. Each cycle a thread may present one insert pulse, one release pulse for an entry freed at issue or at memory completion, and one squash-release pulse for an unissued instruction that was discarded. Inserts are only granted while room remains. A per-thread ceiling, chosen by a sharing policy, keeps one thread from taking over the whole pool.

Three policies set the ceiling. Dynamic sharing lets any thread use the whole pool. Partitioned sharing divides the pool evenly among the threads that are currently active. Threshold sharing caps each thread at a percentage of the pool. A lone active thread still gets the whole pool under the threshold policy. Ceilings are derived combinationally from the live active-thread mask, so a change of the mask takes effect in the same cycle. The dispatch stage reads the free counts and full flags to decide whether it may insert. A sticky error bit records any insert that had to be dropped.

Top module: `iq_share_alloc`

## Requirements
- R1: After reset every thread's occupancy is zero, the global free count equals ENTRIES, every full flag is 0 and the error bit is 0.
- R2: With the policy input at 2'b00 (dynamic), and also at the unused code 2'b11, each thread's ceiling is ENTRIES. A thread's free count is its ceiling minus its occupancy.
- R3: With the policy input at 2'b01 (partitioned), the ceiling of an active thread is ENTRIES divided by the number of set bits in the active mask, rounded down. An inactive thread, or any thread when the mask is empty, gets ENTRIES/THREADS. A change of the mask changes the free counts in the same cycle.
- R4: With the policy input at 2'b10 (threshold), each ceiling is floor(min(pct,100)·ENTRIES/100). If exactly one mask bit is set, that thread's ceiling is ENTRIES.
- R5: A granted insert lowers the global free count by one and raises the thread's occupancy by one, visible after the next rising clock edge.
- R6: A release pulse and a squash-release pulse each return one entry to the thread and to the global count. Both pulses in the same cycle for the same thread return two entries.
- R7: The global full flag is 1 exactly when the global free count is 0. A thread's full flag is 1 exactly when its free count is 0. A free count saturates at 0 when the occupancy exceeds a lowered ceiling.
- R8: An insert is dropped when its thread is full, or when the global pool has no entry left for it. When fewer global entries remain than requests arrive, lower thread indices are granted first. Any dropped insert sets the error bit, which stays set until reset.
- R9: Inserts and releases from all threads in one cycle are added together before the counters update, so that the global free count plus all occupancies always equals ENTRIES.
- R10: A release or squash-release that would take a thread's occupancy below zero is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_req | input | THREADS | Per-thread insert pulse |
| rel_req | input | THREADS | Per-thread release pulse (issued non-memory op or completed memory op) |
| sqr_req | input | THREADS | Per-thread squash-release pulse |
| act_mask | input | THREADS | Active-thread mask |
| policy | input | 2 | Sharing policy: 00 dynamic, 01 partitioned, 10 threshold |
| thr_pct | input | 8 | Threshold percentage, values above 100 treated as 100 |
| glob_free | output | CW | Free entries in the whole pool |
| thr_free | output | THREADS*CW | Per-thread free count, thread t in bits [t*CW +: CW] |
| glob_full | output | 1 | Pool has no free entry |
| thr_full | output | THREADS | Per-thread full flag |
| ovf_err | output | 1 | Sticky dropped-insert flag |

## Verification
Inserting and returning entries can land in the same cycle, for one thread or for several. The bench provokes this by pulsing insert on two threads while one of them also releases, and by pulsing release and squash-release together on a single thread. It judges the result from the expected net change on each thread's free count and on the global count. It also drives all four inserts at once while only two global entries remain, and expects the two lowest-indexed threads to be granted and the error bit to rise.

// File: rtl/iq_share_alloc.sv
module iq_share_alloc #(
  parameter int THREADS = 4,
  parameter int ENTRIES = 32,
  localparam int CW = $clog2(ENTRIES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [THREADS-1:0]    ins_req,
  input  logic [THREADS-1:0]    rel_req,
  input  logic [THREADS-1:0]    sqr_req,
  input  logic [THREADS-1:0]    act_mask,
  input  logic [1:0]            policy,
  input  logic [7:0]            thr_pct,
  output logic [CW-1:0]         glob_free,
  output logic [THREADS*CW-1:0] thr_free,
  output logic                  glob_full,
  output logic [THREADS-1:0]    thr_full,
  output logic                  ovf_err
);

  localparam logic [1:0] POL_PART = 2'b01;
  localparam logic [1:0] POL_THR  = 2'b10;

  logic [CW-1:0] occ_q [THREADS];
  logic [CW-1:0] lim   [THREADS];
  logic [CW-1:0] free_w[THREADS];
  logic [CW-1:0] glob_q;
  logic          ovf_q;

  int            act_cnt;
  logic [CW-1:0] part_lim;
  logic [CW-1:0] pct_lim;

  always_comb begin
    act_cnt = 0;
    for (int t = 0; t < THREADS; t++) act_cnt += int'(act_mask[t]);
  end

  always_comb begin
    part_lim = CW'(ENTRIES / THREADS);
    for (int k = 1; k <= THREADS; k++)
      if (act_cnt == k) part_lim = CW'(ENTRIES / k);
  end

  always_comb begin
    int p;
    p = (thr_pct > 8'd100) ? 100 : int'(thr_pct);
    pct_lim = CW'((p * ENTRIES) / 100);
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    always_comb begin
      case (policy)
        POL_PART: lim[t] = act_mask[t] ? part_lim : CW'(ENTRIES / THREADS);
        POL_THR:  lim[t] = (act_mask[t] && act_cnt == 1) ? CW'(ENTRIES) : pct_lim;
        default:  lim[t] = CW'(ENTRIES);
      endcase
    end
    assign free_w[t] = (lim[t] > occ_q[t]) ? lim[t] - occ_q[t] : '0;
    assign thr_free[t*CW +: CW] = free_w[t];
    assign thr_full[t] = (free_w[t] == '0);
  end

  logic [THREADS-1:0] ins_ok, rel_ok, sqr_ok;
  logic               drop;
  int                 n_ins, n_ret;

  always_comb begin
    n_ins = 0;
    n_ret = 0;
    drop  = 1'b0;
    for (int t = 0; t < THREADS; t++) begin
      ins_ok[t] = ins_req[t] && !thr_full[t] && (n_ins < int'(glob_q));
      if (ins_req[t] && !ins_ok[t]) drop = 1'b1;
      n_ins += int'(ins_ok[t]);
      rel_ok[t] = rel_req[t] && (occ_q[t] != '0);
      sqr_ok[t] = sqr_req[t] && (int'(occ_q[t]) > int'(rel_ok[t]));
      n_ret += int'(rel_ok[t]) + int'(sqr_ok[t]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= CW'(ENTRIES);
      ovf_q  <= 1'b0;
      for (int t = 0; t < THREADS; t++) occ_q[t] <= '0;
    end else begin
      glob_q <= CW'(int'(glob_q) - n_ins + n_ret);
      if (drop) ovf_q <= 1'b1;
      for (int t = 0; t < THREADS; t++)
        occ_q[t] <= CW'(int'(occ_q[t]) + int'(ins_ok[t]) - int'(rel_ok[t]) - int'(sqr_ok[t]));
    end
  end

  assign glob_free = glob_q;
  assign glob_full = (glob_q == '0);
  assign ovf_err   = ovf_q;

  int occ_sum;
  always_comb begin
    occ_sum = 0;
    for (int t = 0; t < THREADS; t++) occ_sum += int'(occ_q[t]);
  end

  a_r9_conserve: assert property (@(posedge clk) disable iff (!rst_n)
    (occ_sum + int'(glob_free)) == ENTRIES);

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

  a_r8_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ins_req) && glob_full) |=> ovf_err);

  a_r5_full_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_full && (rel_req == '0) && (sqr_req == '0)) |=> glob_full);

  a_r10_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(glob_free) <= ENTRIES);

endmodule

// File: tb/iq_share_alloc_tb.sv
module iq_share_alloc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T  = 4;
  localparam int N  = 32;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [T-1:0] ins_req = '0, rel_req = '0, sqr_req = '0, act_mask = '1;
  logic [1:0] policy = 2'b00;
  logic [7:0] thr_pct = 8'd0;
  logic [CW-1:0] glob_free;
  logic [T*CW-1:0] thr_free;
  logic glob_full, ovf_err;
  logic [T-1:0] thr_full;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iq_share_alloc #(.THREADS(T), .ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .ins_req(ins_req), .rel_req(rel_req),
    .sqr_req(sqr_req), .act_mask(act_mask), .policy(policy), .thr_pct(thr_pct),
    .glob_free(glob_free), .thr_free(thr_free), .glob_full(glob_full),
    .thr_full(thr_full), .ovf_err(ovf_err));

  function automatic int fr(input int t);
    return int'(thr_free[t*CW +: CW]);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [T-1:0] i, input logic [T-1:0] r, input logic [T-1:0] s);
    ins_req = i; rel_req = r; sqr_req = s;
    @(negedge clk);
    ins_req = '0; rel_req = '0; sqr_req = '0;
  endtask

  task automatic do_reset(input logic [1:0] pol, input logic [7:0] pct, input logic [T-1:0] m);
    rst_n = 1'b0; policy = pol; thr_pct = pct; act_mask = m;
    ins_req = '0; rel_req = '0; sqr_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset(2'b00, 8'd0, 4'b1111);
    chk("R1 glob_free", int'(glob_free), N);
    for (int t = 0; t < T; t++) chk("R1 thr_free", fr(t), N);
    chk("R1 glob_full", int'(glob_full), 0);
    chk("R1 thr_full", int'(thr_full), 0);
    chk("R1 ovf_err", int'(ovf_err), 0);
  endtask

  task automatic t_dynamic;
    do_reset(2'b00, 8'd0, 4'b1111);
    repeat (3) cyc(4'b0001, '0, '0);
    cyc(4'b0100, '0, '0);
    chk("R5 R2 thr_free0", fr(0), 29);
    chk("R5 thr_free2", fr(2), 31);
    chk("R2 thr_free1", fr(1), 32);
    chk("R5 glob_free", int'(glob_free), 28);
    cyc('0, 4'b0001, 4'b0001);
    chk("R6 thr_free0", fr(0), 31);
    chk("R6 glob_free", int'(glob_free), 30);
    cyc(4'b0101, 4'b0100, '0);
    chk("R9 thr_free0", fr(0), 30);
    chk("R9 thr_free2", fr(2), 31);
    chk("R9 glob_free", int'(glob_free), 29);
    cyc('0, 4'b0010, 4'b0010);
    chk("R10 thr_free1", fr(1), 32);
    chk("R10 glob_free", int'(glob_free), 29);
    policy = 2'b11;
    @(negedge clk);
    chk("R2 code11 thr_free0", fr(0), 30);
  endtask

  task automatic t_partition;
    do_reset(2'b01, 8'd0, 4'b1111);
    chk("R3 thr_free0", fr(0), 8);
    repeat (8) cyc(4'b0010, '0, '0);
    chk("R7 thr_free1", fr(1), 0);
    chk("R7 thr_full1", int'(thr_full[1]), 1);
    chk("R7 ovf before", int'(ovf_err), 0);
    cyc(4'b0010, '0, '0);
    chk("R8 ovf_err", int'(ovf_err), 1);
    chk("R8 glob_free", int'(glob_free), 24);
    act_mask = 4'b0011;
    #1;
    chk("R3 mask0011 thr_free1", fr(1), 8);
    chk("R3 inactive thr_free3", fr(3), 8);
    act_mask = 4'b0001;
    #1;
    chk("R3 mask0001 thr_free0", fr(0), 32);
    chk("R7 saturate thr_free1", fr(1), 0);
    act_mask = 4'b0000;
    #1;
    chk("R3 empty mask thr_free2", fr(2), 8);
    @(negedge clk);
    chk("R8 ovf sticky", int'(ovf_err), 1);
  endtask

  task automatic t_threshold;
    do_reset(2'b10, 8'd30, 4'b1111);
    chk("R4 pct30", fr(0), 9);
    act_mask = 4'b0100;
    #1;
    chk("R4 single active", fr(2), 32);
    chk("R4 other thread", fr(0), 9);
    act_mask = 4'b1111; thr_pct = 8'd150;
    #1;
    chk("R4 pct clamp", fr(3), 32);
    thr_pct = 8'd0;
    #1;
    chk("R4 pct0 full", int'(thr_full), 15);
    @(negedge clk);
  endtask

  task automatic t_global;
    do_reset(2'b00, 8'd0, 4'b1111);
    repeat (30) cyc(4'b0001, '0, '0);
    chk("R5 glob_free 30in", int'(glob_free), 2);
    cyc(4'b1111, '0, '0);
    chk("R8 arb thr_free0", fr(0), 1);
    chk("R8 arb thr_free1", fr(1), 31);
    chk("R8 arb thr_free2", fr(2), 32);
    chk("R7 glob_free", int'(glob_free), 0);
    chk("R7 glob_full", int'(glob_full), 1);
    chk("R8 ovf arb", int'(ovf_err), 1);
    cyc('0, '0, 4'b0010);
    chk("R6 squash glob", int'(glob_free), 1);
    chk("R7 glob_full clr", int'(glob_full), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_dynamic();
    t_partition();
    t_threshold();
    t_global();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule